// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block serializes two's-complement audio words onto a single data line while acting as clock master. From the system clock it derives a bit clock by integer division. It also drives a sync line that acts as a word-select or a frame marker, depending on the framing in use. One shifter covers five framings: the standard two-channel stereo format, a left-aligned stereo format, a right-aligned stereo format, and two multi-word PCM framings. One PCM framing marks a frame with a one-period sync pulse and the other with a sync pulse of configurable width.

Samples enter on a valid/ready stream, one word per slot. Static configuration inputs set the word length, slot length, words per PCM frame, sync width, bit order, bit-clock and sync polarity, the division ratio, and whether the bit clock runs continuously or only while frames carry data. A copy of the serial data is brought out so that a receiver under test can be wired straight to the transmitter.

Top module: `audio_serial_tx`

## Requirements
- R1: While `enable` is low the block is idle: `sdata_o` = 0, `in_ready` = 0, `underrun_o` = 0, `fsync_o` = `cfg_fclk_inv`, and `bclk_o` = first-half level XOR `cfg_bclk_inv`. The first-half level is 0 for formats 0, 3 and 4 and 1 for formats 1 and 2.
- R2: One bit period lasts `cfg_div` system cycles, and a value below 2 counts as 2. A slot spans `cfg_slot_len` periods. Data and sync change only at the start of a period, when the bit clock returns to its first-half level. The receiver samples at mid-period, which is a rising edge for formats 0, 3 and 4 and a falling edge for formats 1 and 2 (before inversion).
- R3: With `cfg_fmt` = 0 (standard stereo), a frame is two slots. The sync line is low in the first (left) slot and high in the second (right) slot. Each word's first bit is sent one period after the sync changes.
- R4: With `cfg_fmt` = 3 (left-aligned), a frame is two slots. The sync line is high in the left slot and low in the right slot, and the first bit goes out in period 0 of the slot.
- R5: With `cfg_fmt` = 4 (right-aligned), the sync line works as in R4. The last bit of a word goes out in the final period of its slot, and the leading periods carry 0.
- R6: With `cfg_fmt` = 1 (short sync), a frame is `cfg_frame_words` slots packed back to back. The sync line is high only in the final period of each frame.
- R7: With `cfg_fmt` = 2 (wide sync), a frame is `cfg_frame_words` slots. The sync line is high during the first `cfg_sync_len` periods of each frame.
- R8: `cfg_lsb_first` = 0 sends bit `cfg_word_len`-1 first and = 1 sends bit 0 first. Periods of a slot beyond the word carry 0.
- R9: `cfg_fclk_inv` = 1 inverts the sync line, and `cfg_bclk_inv` = 1 inverts the bit clock.
- R10: `in_ready` is a one-cycle pulse at the start of every slot, and the word in `in_data[cfg_word_len-1:0]` is taken then. Words are sent in the order they were accepted.
- R11: If `in_valid` is low when a slot starts, that slot carries all zeros and `underrun_o` pulses for one cycle.
- R12: With `cfg_gated` = 1, a frame starts only if a word is valid at its start, and no underrun is flagged there. Otherwise the bit clock holds its first-half level. The clock makes exactly two transitions per transmitted period.
- R13: `loop_sd_o` always equals `sdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the transmitter; low returns it to idle |
| cfg_fmt | input | 3 | Framing: 0 stereo, 1 short sync, 2 wide sync, 3 left-aligned, 4 right-aligned |
| cfg_word_len | input | CNT_W | Bits per word |
| cfg_slot_len | input | CNT_W | Bit periods per slot |
| cfg_frame_words | input | WORDS_W | Slots per frame in PCM framings |
| cfg_sync_len | input | CNT_W | Wide-sync pulse width in periods |
| cfg_lsb_first | input | 1 | Send least significant bit first |
| cfg_bclk_inv | input | 1 | Invert bit clock |
| cfg_fclk_inv | input | 1 | Invert sync line |
| cfg_gated | input | 1 | Run the bit clock only while frames carry data |
| cfg_div | input | DIV_W | System cycles per bit period |
| in_valid | input | 1 | Sample word present |
| in_ready | output | 1 | Sample word taken this cycle |
| in_data | input | WORD_MAX | Sample word, LSB-aligned |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Word-select / frame sync |
| sdata_o | output | 1 | Serial data |
| loop_sd_o | output | 1 | Serial data copy for a receiver under test |
| underrun_o | output | 1 | Slot started without a sample |

## Verification
The bench builds the block with its defaults: 16-bit words, 6-bit slot and sync counters, 4-bit frame-word count and an 8-bit divider. It sweeps short slots of 6 and 7 periods, 3-word PCM frames and dividers of 1, 2 and 3. At that size every framing can be combined with both bit orders and both polarities. The bench decodes each sampling edge against an arithmetic model of the expected stream. That model reaches the case where a full-width word spills its last bit into the next slot, the underrun of a single slot in mid-stream, and a gated stream that stops cleanly after two frames.

// File: rtl/atx_pkg.sv
package atx_pkg;

  typedef enum logic [2:0] {
    FMT_STD        = 3'd0,
    FMT_SYNC_PULSE = 3'd1,
    FMT_SYNC_WIDE  = 3'd2,
    FMT_MSB_ALIGN  = 3'd3,
    FMT_LSB_ALIGN  = 3'd4
  } atx_fmt_e;

  // PCM framings: many words per frame, data launched on rising clock
  function automatic logic fmt_is_tdm(input logic [2:0] f);
    return (f == FMT_SYNC_PULSE) || (f == FMT_SYNC_WIDE);
  endfunction

  // Bit clock level during the first half of a period (launch half)
  function automatic logic launch_level(input logic [2:0] f);
    return fmt_is_tdm(f);
  endfunction

endpackage

// File: rtl/atx_bitclk.sv
module atx_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  input  logic             idle_lvl,
  input  logic             live,
  output logic             launch,
  output logic             bclk
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] cnt, div_eff, half_at;
  logic             mid, base;

  assign div_eff = (div < MIN_DIV) ? MIN_DIV : div;
  assign half_at = (div_eff >> 1) - DIV_W'(1);
  assign launch  = enable && (cnt == div_eff - DIV_W'(1));
  assign mid     = enable && (cnt == half_at);
  assign bclk    = enable ? base : idle_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt  <= '0;
      base <= idle_lvl;
    end else begin
      cnt <= launch ? '0 : cnt + DIV_W'(1);
      if (launch)          base <= idle_lvl;
      else if (mid && live) base <= ~idle_lvl;
    end
  end

  // gated clock holds still while no period is live
  assert_gated_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !live && $past(!live)) |-> $stable(bclk));

endmodule

// File: rtl/atx_framer.sv
module atx_framer #(
  parameter int CNT_W   = 6,
  parameter int WORDS_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               launch,
  input  logic [CNT_W-1:0]   slot_len,
  input  logic [WORDS_W-1:0] nslots,
  input  logic               gated,
  input  logic               in_valid,
  output logic [CNT_W-1:0]   p_n,
  output logic [WORDS_W-1:0] s_n,
  output logic               live_n,
  output logic               live_q,
  output logic               slot_begin
);
  logic [CNT_W-1:0]   p;
  logic [WORDS_W-1:0] s;
  logic               fresh, fresh_n, slot_end, at_end;

  always_comb begin
    slot_end = (p == slot_len - CNT_W'(1));
    at_end   = fresh || (slot_end && (s == nslots - WORDS_W'(1)));
    p_n      = p;
    s_n      = s;
    live_n   = live_q;
    fresh_n  = fresh;
    if (at_end) begin
      if (!gated || in_valid) begin
        p_n = '0; s_n = '0; live_n = 1'b1; fresh_n = 1'b0;
      end else begin
        live_n = 1'b0; fresh_n = 1'b1;
      end
    end else if (slot_end) begin
      p_n = '0;
      s_n = s + WORDS_W'(1);
    end else begin
      p_n = p + CNT_W'(1);
    end
  end

  assign slot_begin = launch && live_n && (p_n == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      p      <= '0;
      s      <= '0;
      fresh  <= 1'b1;
      live_q <= 1'b0;
    end else if (launch) begin
      p      <= p_n;
      s      <= s_n;
      fresh  <= fresh_n;
      live_q <= live_n;
    end
  end

  assert_pos_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (p < slot_len));

endmodule

// File: rtl/atx_slotmap.sv
module atx_slotmap
  import atx_pkg::*;
#(
  parameter int WORD_MAX = 16,
  parameter int CNT_W    = 6,
  parameter int WORDS_W  = 4
) (
  input  logic [2:0]          fmt,
  input  logic [CNT_W-1:0]    p,
  input  logic [WORDS_W-1:0]  s,
  input  logic [WORDS_W-1:0]  nslots,
  input  logic [CNT_W-1:0]    word_len,
  input  logic [CNT_W-1:0]    slot_len,
  input  logic [CNT_W-1:0]    sync_len,
  input  logic                lsb_first,
  input  logic [WORD_MAX-1:0] word,
  output logic                bit_o,
  output logic                ws_o
);
  logic [CNT_W-1:0]    pad, k, idx;
  logic                have;
  logic [WORD_MAX-1:0] shifted;

  always_comb begin
    pad = slot_len - word_len;
    if (fmt == FMT_LSB_ALIGN) begin
      have = (p >= pad);
      k    = p - pad;
    end else begin
      have = (p < word_len);
      k    = p;
    end
    idx     = lsb_first ? k : (word_len - CNT_W'(1) - k);
    shifted = word >> idx;
    bit_o   = have && shifted[0];

    case (fmt)
      FMT_STD:        ws_o = (s == WORDS_W'(1));
      FMT_SYNC_PULSE: ws_o = (p == slot_len - CNT_W'(1)) &&
                             (s == nslots - WORDS_W'(1));
      FMT_SYNC_WIDE:  ws_o = (s == '0) && (p < sync_len);
      default:        ws_o = (s == '0);
    endcase
  end

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import atx_pkg::*;
#(
  parameter int WORD_MAX = 16,
  parameter int CNT_W    = 6,
  parameter int WORDS_W  = 4,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [2:0]          cfg_fmt,
  input  logic [CNT_W-1:0]    cfg_word_len,
  input  logic [CNT_W-1:0]    cfg_slot_len,
  input  logic [WORDS_W-1:0]  cfg_frame_words,
  input  logic [CNT_W-1:0]    cfg_sync_len,
  input  logic                cfg_lsb_first,
  input  logic                cfg_bclk_inv,
  input  logic                cfg_fclk_inv,
  input  logic                cfg_gated,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_MAX-1:0] in_data,
  output logic                bclk_o,
  output logic                fsync_o,
  output logic                sdata_o,
  output logic                loop_sd_o,
  output logic                underrun_o
);
  localparam logic [WORDS_W-1:0] STEREO_SLOTS = WORDS_W'(2);

  logic                tdm, lvl, launch, bclk_raw, live_q, live_n, slot_begin;
  logic                bit_now, ws_now;
  logic [WORDS_W-1:0]  nslots, s_n;
  logic [CNT_W-1:0]    slot_eff, p_n;
  logic [WORD_MAX-1:0] cur_word, word_now;
  logic                sd_q, ws_q, lead_q, under_q;

  assign tdm      = fmt_is_tdm(cfg_fmt);
  assign lvl      = launch_level(cfg_fmt);
  assign nslots   = !tdm ? STEREO_SLOTS :
                    (cfg_frame_words == '0) ? WORDS_W'(1) : cfg_frame_words;
  assign slot_eff = (cfg_slot_len == '0) ? CNT_W'(1) : cfg_slot_len;

  atx_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div(cfg_div),
    .idle_lvl(lvl), .live(live_q), .launch(launch), .bclk(bclk_raw)
  );

  atx_framer #(.CNT_W(CNT_W), .WORDS_W(WORDS_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .launch(launch),
    .slot_len(slot_eff), .nslots(nslots), .gated(cfg_gated),
    .in_valid(in_valid), .p_n(p_n), .s_n(s_n), .live_n(live_n),
    .live_q(live_q), .slot_begin(slot_begin)
  );

  // word on the line during the period being launched
  assign word_now = slot_begin ? (in_valid ? in_data : '0) : cur_word;

  atx_slotmap #(.WORD_MAX(WORD_MAX), .CNT_W(CNT_W), .WORDS_W(WORDS_W)) u_map (
    .fmt(cfg_fmt), .p(p_n), .s(s_n), .nslots(nslots),
    .word_len(cfg_word_len), .slot_len(slot_eff), .sync_len(cfg_sync_len),
    .lsb_first(cfg_lsb_first), .word(word_now), .bit_o(bit_now), .ws_o(ws_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cur_word <= '0;
      sd_q     <= 1'b0;
      ws_q     <= 1'b0;
      lead_q   <= 1'b0;
      under_q  <= 1'b0;
    end else begin
      under_q <= slot_begin && !in_valid;
      if (launch) begin
        cur_word <= word_now;
        lead_q   <= live_n && bit_now;
        // stereo format trails the aligned bit stream by one period
        sd_q     <= live_n && ((cfg_fmt == FMT_STD) ? lead_q : bit_now);
        ws_q     <= live_n && ws_now;
      end
    end
  end

  assign in_ready   = slot_begin;
  assign underrun_o = under_q;
  assign bclk_o     = bclk_raw ^ cfg_bclk_inv;
  assign fsync_o    = ws_q ^ cfg_fclk_inv;
  assign sdata_o    = sd_q;
  assign loop_sd_o  = sd_q;

  assert_ready_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  assert_underrun_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_o && (cfg_fmt != FMT_STD)) |-> !sdata_o);

  assert_line_at_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$past(launch)) |-> ($stable(fsync_o) && $stable(sdata_o)));

  assert_loop_copy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    loop_sd_o == sdata_o);

endmodule

// File: tb/audio_serial_tx_tb.sv
module audio_serial_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NONE = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [2:0]  cfg_fmt = '0;
  logic [5:0]  cfg_word_len = 6'd4, cfg_slot_len = 6'd6, cfg_sync_len = 6'd2;
  logic [3:0]  cfg_frame_words = 4'd3;
  logic        cfg_lsb_first = 0, cfg_bclk_inv = 0, cfg_fclk_inv = 0, cfg_gated = 0;
  logic [7:0]  cfg_div = 8'd2;
  logic        in_valid, in_ready;
  logic [15:0] in_data;
  logic        bclk_o, fsync_o, sdata_o, loop_sd_o, underrun_o;

  int checks = 0, errors = 0;
  int t_fmt = 0, t_w = 4, t_s = 6, t_f = 3, t_l = 2, t_div = 2, t_hole = NONE, t_limit = NONE;
  bit t_lsb = 0, t_binv = 0, t_finv = 0, t_gated = 0;
  int cs = 0, n = 0, cyc = 0, ecnt = 0, ucnt = 0;
  bit took = 0, feed_on = 0, mon_on = 0, prev_b = 0, prev_ready = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_serial_tx u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_fmt(cfg_fmt),
    .cfg_word_len(cfg_word_len), .cfg_slot_len(cfg_slot_len),
    .cfg_frame_words(cfg_frame_words), .cfg_sync_len(cfg_sync_len),
    .cfg_lsb_first(cfg_lsb_first), .cfg_bclk_inv(cfg_bclk_inv),
    .cfg_fclk_inv(cfg_fclk_inv), .cfg_gated(cfg_gated), .cfg_div(cfg_div),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .bclk_o(bclk_o), .fsync_o(fsync_o), .sdata_o(sdata_o),
    .loop_sd_o(loop_sd_o), .underrun_o(underrun_o)
  );

  function automatic int sample_of(int i, int w);
    return ((i * 53 + 29) ^ (i >> 2)) & ((1 << w) - 1);
  endfunction

  function automatic bit is_tdm(int f);
    return (f == 1) || (f == 2);
  endfunction

  function automatic int slot_word(int g);
    if (g == t_hole) return 0;
    return sample_of((g > t_hole) ? g - 1 : g, t_w);
  endfunction

  assign in_valid = feed_on && (cs != t_hole) && (cs < t_limit);
  assign in_data  = 16'(sample_of((cs > t_hole) ? cs - 1 : cs, t_w));

  // aligned-stream bit for period m (stereo format reads period m-1)
  function automatic bit exp_bit(int m);
    int g, p, k, idx, wd;
    if (m < 0) return 1'b0;
    g = m / t_s; p = m % t_s; wd = slot_word(g);
    if (t_fmt == 4) begin
      if (p < t_s - t_w) return 1'b0;
      k = p - (t_s - t_w);
    end else begin
      if (p >= t_w) return 1'b0;
      k = p;
    end
    idx = t_lsb ? k : (t_w - 1 - k);
    return ((wd >> idx) & 1) != 0;
  endfunction

  function automatic bit exp_ws(int m);
    int g, p, fe;
    fe = is_tdm(t_fmt) ? t_f : 2;
    g = m / t_s; p = m % t_s;
    case (t_fmt)
      0: return (g % 2) == 1;
      1: return (p == t_s - 1) && ((g % fe) == fe - 1);
      2: return ((g % fe) == 0) && (p < t_l);
      default: return (g % 2) == 0;
    endcase
  endfunction

  function automatic string fmt_tag();
    case (t_fmt)
      0: return "R3";
      1: return "R6";
      2: return "R7";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s fmt=%0d period=%0d actual=%0d expected=%0d", tag, t_fmt, n, act, exp);
    end
  endtask

  // sample handshake bookkeeping: a slot is counted after its ready pulse
  initial begin
    forever begin
      @(negedge clk);
      if (took) cs++;
      took = in_ready && enable;
    end
  end

  // receiver model: decode at each sampling edge
  initial begin
    bit b, eb, samp_lvl;
    string dtag;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        b = bclk_o ^ t_binv;
        samp_lvl = !is_tdm(t_fmt);
        cyc++;
        if (b != prev_b) begin
          ecnt++;
          if (b == samp_lvl) begin
            if (n > 0 && !t_gated) chk(cyc == ((t_div < 2) ? 2 : t_div), "R2", cyc, (t_div < 2) ? 2 : t_div);
            cyc = 0;
            eb = (t_fmt == 0) ? exp_bit(n - 1) : exp_bit(n);
            dtag = t_lsb ? {fmt_tag(), "/R8"} : fmt_tag();
            if (t_hole != NONE) dtag = {dtag, "/R11"};
            chk(sdata_o == eb, dtag, sdata_o, eb);
            chk((fsync_o ^ t_finv) == exp_ws(n), t_finv ? {fmt_tag(), "/R9"} : fmt_tag(),
                fsync_o, exp_ws(n) ^ t_finv);
            chk(loop_sd_o == sdata_o, "R13", loop_sd_o, sdata_o);
            n++;
          end
        end
        prev_b = b;
        if (underrun_o) ucnt++;
        if (in_ready) chk(!prev_ready, "R10", 1, 0);
        prev_ready = in_ready;
      end
    end
  end

  task automatic run_one(int fmt, int w, int s, int f, int l, bit lsb, bit binv,
                         bit finv, bit gated, int div, int hole, int limit, int nper);
    int fe, guard;
    @(negedge clk);
    enable = 0; feed_on = 0;
    t_fmt = fmt; t_w = w; t_s = s; t_f = f; t_l = l; t_lsb = lsb; t_binv = binv;
    t_finv = finv; t_gated = gated; t_div = div; t_hole = hole; t_limit = limit;
    cfg_fmt = 3'(fmt); cfg_word_len = 6'(w); cfg_slot_len = 6'(s);
    cfg_frame_words = 4'(f); cfg_sync_len = 6'(l); cfg_lsb_first = lsb;
    cfg_bclk_inv = binv; cfg_fclk_inv = finv; cfg_gated = gated; cfg_div = 8'(div);
    repeat (3) @(negedge clk);
    // R1: idle levels while disabled
    chk(bclk_o == (is_tdm(fmt) ^ binv), "R1", bclk_o, is_tdm(fmt) ^ binv);
    chk(fsync_o == finv && sdata_o == 0 && in_ready == 0 && underrun_o == 0, "R1",
        {fsync_o, sdata_o, in_ready, underrun_o}, {finv, 3'b000});
    fe = is_tdm(fmt) ? f : 2;
    cs = 0; took = 0; n = 0; cyc = 0; ecnt = 0; ucnt = 0;
    prev_b = is_tdm(fmt); prev_ready = 0;
    feed_on = 1; mon_on = 1; enable = 1;
    if (!gated) begin
      guard = 0;
      while (n < nper && guard < 20000) begin @(negedge clk); guard++; end
      chk(n >= nper, "R2", n, nper);
    end else begin
      repeat ((limit * s + 2 * fe * s) * ((div < 2) ? 2 : div) + 20) @(negedge clk);
      chk(n == limit * s, "R12", n, limit * s);
      chk(ecnt == 2 * limit * s, "R12", ecnt, 2 * limit * s);
    end
    mon_on = 0;
    @(negedge clk);
    enable = 0; feed_on = 0;
    chk(ucnt == ((hole != NONE) ? 1 : 0), gated ? "R12" : "R11", ucnt, (hole != NONE) ? 1 : 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int fe;
    repeat (4) @(negedge clk);
    chk(sdata_o == 0 && in_ready == 0 && underrun_o == 0 && bclk_o == 0, "R1",
        {sdata_o, in_ready, underrun_o, bclk_o}, 0);
    rst_n = 1;
    // main sweep: every framing, bit order, polarity, partial and full-width words
    for (int fmt = 0; fmt < 5; fmt++) begin
      fe = is_tdm(fmt) ? 3 : 2;
      for (int wc = 0; wc < 2; wc++)
        for (int lsb = 0; lsb < 2; lsb++)
          for (int bi = 0; bi < 2; bi++)
            for (int fi = 0; fi < 2; fi++)
              run_one(fmt, (wc != 0) ? 6 : 4, 6, 3, 2, lsb[0], bi[0], fi[0], 1'b0,
                      2, NONE, NONE, 3 * fe * 6);
    end
    // single-slot underrun in mid-stream, odd divider
    for (int fmt = 0; fmt < 5; fmt++) begin
      fe = is_tdm(fmt) ? 3 : 2;
      run_one(fmt, 5, 7, 3, 3, 1'b0, 1'b0, 1'b0, 1'b0, 3, 2, NONE, 3 * fe * 7);
    end
    // gated clock: two frames then the stream dries up
    for (int fmt = 0; fmt < 5; fmt++) begin
      fe = is_tdm(fmt) ? 2 : 2;
      run_one(fmt, 4, 6, 2, 2, 1'b1, 1'b0, 1'b1, 1'b1, 2, NONE, 2 * fe, 0);
    end
    // divider below the minimum is clamped (R2)
    run_one(3, 4, 6, 2, 2, 1'b0, 1'b0, 1'b0, 1'b0, 1, NONE, NONE, 24);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule